// File: doc/BRIEF.md
# Memory-Map Region Decoder with Access Quirks

This block sits between a processor's load/store port and the memories behind it. Every access is decoded from address bits [27:24]. The decode picks one memory select and folds the address down to that memory's size, so each smaller memory repeats across its whole 16 MiB window. Reads return the addressed word, halfword or byte already formatted, including the rotation that unaligned reads get. Writes come out as a byte-lane mask and replicated data, with the region-specific filtering already applied.

Two regions behave unusually:

- **Boot ROM** has its own read port and is guarded. It returns true contents only while the program counter is executing from it. Otherwise it returns a protected word, captured from the fetch stream before execution left.
- **Video memory** treats byte stores in a special way. A byte store is widened to a full halfword or dropped, depending on where it lands.

The memories themselves are not part of this block. They read asynchronously, and all access timing is handled elsewhere. The only storage in the block is the protected boot word.

Top module: `region_decoder`

## Requirements
- R1: Region = req_addr[27:24]. On a valid access, mem_sel bit 0..6 is raised alone for regions 2 (external work RAM), 3 (internal work RAM), 4 (I/O), 5 (palette), 6 (video), 7 (object memory) and 8 to 13 (cartridge) respectively. Regions 0, 1, 14 and 15 raise no select.
- R2: mem_addr carries the in-region offset masked to the memory size: 18 bits for external RAM, 15 for internal RAM, 10 for I/O, palette and object memory, and 17 for video. For cartridge it is the 25-bit value {req_addr[24], req_addr[23:0]}. It is 0 for regions with no select.
- R3: A word read (req_size 2, or 3, which is treated as a word) returns the word from memory rotated right by 8 × req_addr[1:0] bits.
- R4: A halfword read (req_size 1) takes the halfword picked by req_addr[1], rotates it right by 8 × req_addr[0] bits and zero-extends it. A byte read (req_size 0) returns byte lane req_addr[1:0], zero-extended.
- R5: While cur_pc[27:24] is 0, a boot-ROM read returns boot_rdata, formatted as in R3/R4, when req_addr[23:14] is 0. It returns 0 otherwise. boot_addr then carries req_addr[13:0].
- R6: While the program counter is in region 0 and no boot-ROM data read is in progress, boot_addr points at the word at cur_pc + 8 (or + 4 when cur_thumb is 1), and that word is stored at each clock edge. The stored word resets to 0. A boot-ROM read made while the program counter is outside region 0 returns the stored word, formatted.
- R7: A cartridge read whose masked offset is at or beyond rom_size returns 0.
- R8: Reads from regions with no select return 0. Writes to those regions, to boot ROM and to cartridge never raise mem_we.
- R9: An accepted write sets mem_we. A word sets mem_be 4'b1111 and passes the data unchanged. A halfword sets mem_be 4'b0011 or 4'b1100 by req_addr[1] and puts the low halfword in both halves. A byte sets one lane bit (1 << req_addr[1:0]) and puts the low byte in all four lanes.
- R10: A byte write to video memory at offset req_addr[23:0] below 0x18000 enables both bytes of the addressed halfword. At or above 0x18000 it is dropped (mem_we 0, mem_be 0).
- R11: Byte writes to palette and object memory are dropped. Halfword and word writes to them are accepted.
- R12: A word write to video memory with req_addr[23:0] at or above 0x17FFE is dropped.
- R13: With req_valid low, mem_sel, mem_we, mem_be and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the protected boot word |
| req_valid | input | 1 | Access present this cycle |
| req_wr | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| cur_pc | input | 32 | Program counter of the executing instruction |
| cur_thumb | input | 1 | 1 when executing 16-bit instructions |
| rom_size | input | 26 | Cartridge ROM size in bytes |
| mem_sel | output | 7 | One-hot memory select |
| mem_addr | output | 25 | Masked in-region byte offset |
| mem_we | output | 1 | Write strobe after filtering |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Aligned word from the selected memory |
| boot_addr | output | 14 | Boot-ROM byte address (data read or look-ahead) |
| boot_rdata | input | 32 | Aligned word from boot ROM |
| rd_data | output | 32 | Formatted load result |

## Verification
The hardest state to reach is the protected boot word holding a value that differs from reset. That takes a program counter parked inside region 0 with the boot port idle for at least one edge, followed by a load issued after the counter has moved elsewhere. The bench models boot ROM as a function of boot_addr, so every look-ahead word is distinct. It parks the counter in 32-bit and in 16-bit instruction mode. It checks that loads made while the boot port is busy leave the captured word alone, and that the word stays put once the counter has left.

// File: rtl/region_decoder.sv
module region_decoder #(
  parameter int BOOT_AW   = 14,
  parameter int EWRAM_AW  = 18,
  parameter int IWRAM_AW  = 15,
  parameter int IO_AW     = 10,
  parameter int PAL_AW    = 10,
  parameter int VRAM_AW   = 17,
  parameter int OAM_AW    = 10,
  parameter int CART_AW   = 25,
  parameter int VRAM_BYTES = 32'h18000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_wr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [31:0]        cur_pc,
  input  logic               cur_thumb,
  input  logic [CART_AW:0]   rom_size,
  output logic [6:0]         mem_sel,
  output logic [CART_AW-1:0] mem_addr,
  output logic               mem_we,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic [BOOT_AW-1:0] boot_addr,
  input  logic [31:0]        boot_rdata,
  output logic [31:0]        rd_data
);

  localparam int MA_W = CART_AW;
  localparam logic [23:0] VRAM_LIM  = 24'(VRAM_BYTES);
  localparam logic [23:0] VRAM_WLIM = 24'(VRAM_BYTES - 2);

  logic [3:0]  region;
  logic [23:0] offs;
  logic        is_byte, is_half, is_word;
  logic        pc_in_boot, boot_rd, cart_rgn, cart_over;
  logic [CART_AW-1:0] cart_off;
  logic [BOOT_AW-1:0] peek;
  logic [31:0] prot_q, src, fmt;
  logic [63:0] dbl;
  logic [15:0] hsel;
  logic        drop, wr_ok;
  logic [3:0]  be_raw;
  logic        unused_hi;

  assign region  = req_addr[27:24];
  assign offs    = req_addr[23:0];
  assign is_byte = (req_size == 2'd0);
  assign is_half = (req_size == 2'd1);
  assign is_word = req_size[1];

  assign pc_in_boot = (cur_pc[27:24] == 4'h0);
  assign boot_rd    = req_valid && !req_wr && (region == 4'h0);
  assign cart_rgn   = (region >= 4'h8) && (region <= 4'hD);
  assign cart_off   = CART_AW'({region[0], offs});
  assign cart_over  = {1'b0, cart_off} >= rom_size;

  assign peek      = cur_pc[BOOT_AW-1:0] + BOOT_AW'(cur_thumb ? 4 : 8);
  assign boot_addr = boot_rd ? offs[BOOT_AW-1:0] : {peek[BOOT_AW-1:2], 2'b00};
  assign unused_hi = ^{req_addr[31:28], cur_pc[31:28], cur_pc[23:BOOT_AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prot_q <= '0;
    else if (pc_in_boot && !boot_rd)
      prot_q <= boot_rdata;
  end

  always_comb begin
    mem_sel  = '0;
    mem_addr = '0;
    if (req_valid) begin
      case (region)
        4'h2: begin mem_sel = 7'b0000001; mem_addr = MA_W'(offs[EWRAM_AW-1:0]); end
        4'h3: begin mem_sel = 7'b0000010; mem_addr = MA_W'(offs[IWRAM_AW-1:0]); end
        4'h4: begin mem_sel = 7'b0000100; mem_addr = MA_W'(offs[IO_AW-1:0]);    end
        4'h5: begin mem_sel = 7'b0001000; mem_addr = MA_W'(offs[PAL_AW-1:0]);   end
        4'h6: begin mem_sel = 7'b0010000; mem_addr = MA_W'(offs[VRAM_AW-1:0]);  end
        4'h7: begin mem_sel = 7'b0100000; mem_addr = MA_W'(offs[OAM_AW-1:0]);   end
        4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:
              begin mem_sel = 7'b1000000; mem_addr = cart_off; end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (region == 4'h0) begin
      if (pc_in_boot)
        src = (offs[23:BOOT_AW] == '0) ? boot_rdata : 32'h0;
      else
        src = prot_q;
    end else if (cart_rgn) begin
      src = cart_over ? 32'h0 : mem_rdata;
    end else if (region >= 4'h2 && region <= 4'h7) begin
      src = mem_rdata;
    end else begin
      src = 32'h0;
    end
  end

  assign dbl  = {src, src} >> {req_addr[1:0], 3'b000};
  assign hsel = req_addr[1] ? src[31:16] : src[15:0];

  always_comb begin
    if (is_word)
      fmt = dbl[31:0];
    else if (is_half)
      fmt = {16'h0, req_addr[0] ? {hsel[7:0], hsel[15:8]} : hsel};
    else
      fmt = {24'h0, dbl[7:0]};
  end

  assign rd_data = (req_valid && !req_wr) ? fmt : 32'h0;

  always_comb begin
    drop = 1'b0;
    if (region == 4'h5 || region == 4'h7)
      drop = is_byte;
    else if (region == 4'h6)
      drop = (is_byte && offs >= VRAM_LIM) || (is_word && offs >= VRAM_WLIM);
  end

  assign wr_ok = req_valid && req_wr && (region >= 4'h2) && (region <= 4'h7) && !drop;

  always_comb begin
    if (is_word)
      be_raw = 4'b1111;
    else if (is_half || region == 4'h6)
      be_raw = req_addr[1] ? 4'b1100 : 4'b0011;
    else
      be_raw = 4'b0001 << req_addr[1:0];
  end

  assign mem_we = wr_ok;
  assign mem_be = wr_ok ? be_raw : 4'b0000;
  assign mem_wdata = is_word ? req_wdata :
                     is_half ? {2{req_wdata[15:0]}} : {4{req_wdata[7:0]}};

endmodule

module region_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_wr,
  input logic [1:0]  req_size,
  input logic [31:0] req_addr,
  input logic [31:0] cur_pc,
  input logic [6:0]  mem_sel,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] rd_data
);
  logic [3:0] rgn;
  logic       boot_out, boot_load;
  assign rgn       = req_addr[27:24];
  assign boot_out  = cur_pc[27:24] != 4'h0;
  assign boot_load = req_valid && !req_wr && rgn == 4'h0;

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_sel));

  // R8
  we_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_valid && req_wr && mem_sel != 7'b0));

  // R9
  be_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be != 4'b0000);

  // R11
  small_byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && req_size == 2'd0 && (rgn == 4'h5 || rgn == 4'h7)) |-> !mem_we);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr && (rgn == 4'h1 || rgn >= 4'hE)) |-> rd_data == 32'h0);

  // R6
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_load && boot_out && $past(boot_load) && $past(boot_out) &&
     $stable(req_addr) && $stable(req_size)) |-> $stable(rd_data));
endmodule

bind region_decoder region_decoder_chk u_region_decoder_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
  .req_size(req_size), .req_addr(req_addr), .cur_pc(cur_pc),
  .mem_sel(mem_sel), .mem_we(mem_we), .mem_be(mem_be), .rd_data(rd_data)
);

// File: tb/region_decoder_bench.sv
module region_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0, cur_thumb = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0, cur_pc = 32'h0800_0000;
  logic [25:0] rom_size = 26'h010_0000;
  logic [6:0]  mem_sel;
  logic [24:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, rd_data, boot_rdata;
  logic [31:0] mem_rdata = 32'h8899_AABB;
  logic [13:0] boot_addr;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign boot_rdata = 32'hA5A5_0000 | {18'b0, boot_addr[13:2], 2'b00};

  region_decoder u_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cur_pc(cur_pc), .cur_thumb(cur_thumb), .rom_size(rom_size),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .boot_addr(boot_addr),
    .boot_rdata(boot_rdata), .rd_data(rd_data)
  );

  // {addr, size, expected rd_data, expected sel, expected mem_addr}
  localparam logic [97:0] RD_TAB [0:17] = '{
    {32'h0200_0000, 2'd2, 32'h8899_AABB, 7'h01, 25'h000_0000},
    {32'h0200_0001, 2'd2, 32'hBB88_99AA, 7'h01, 25'h000_0001},
    {32'h0300_0002, 2'd2, 32'hAABB_8899, 7'h02, 25'h000_0002},
    {32'h03FF_FFFF, 2'd2, 32'h99AA_BB88, 7'h02, 25'h000_7FFF},
    {32'h0500_0001, 2'd1, 32'h0000_BBAA, 7'h08, 25'h000_0001},
    {32'h0700_0003, 2'd1, 32'h0000_9988, 7'h20, 25'h000_0003},
    {32'h0600_0002, 2'd0, 32'h0000_0099, 7'h10, 25'h000_0002},
    {32'h0400_0001, 2'd0, 32'h0000_00AA, 7'h04, 25'h000_0001},
    {32'h0800_0010, 2'd2, 32'h8899_AABB, 7'h40, 25'h000_0010},
    {32'h0810_0000, 2'd2, 32'h0000_0000, 7'h40, 25'h010_0000},
    {32'h0C0F_FFFC, 2'd2, 32'h8899_AABB, 7'h40, 25'h00F_FFFC},
    {32'h0900_0000, 2'd2, 32'h0000_0000, 7'h40, 25'h100_0000},
    {32'h0100_0000, 2'd2, 32'h0000_0000, 7'h00, 25'h000_0000},
    {32'h0F00_0000, 2'd1, 32'h0000_0000, 7'h00, 25'h000_0000},
    {32'h0E00_0000, 2'd0, 32'h0000_0000, 7'h00, 25'h000_0000},
    {32'h0204_0004, 2'd2, 32'h8899_AABB, 7'h01, 25'h000_0004},
    {32'h0601_FFFD, 2'd1, 32'h0000_BBAA, 7'h10, 25'h001_FFFD},
    {32'h0200_0002, 2'd3, 32'hAABB_8899, 7'h01, 25'h000_0002}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic v, input logic w, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] d,
                     input logic [31:0] pc, input logic th);
    @(negedge clk);
    req_valid = v; req_wr = w; req_size = sz; req_addr = a; req_wdata = d;
    cur_pc = pc; cur_thumb = th;
    #2;
  endtask

  task automatic wchk(input string tag, input logic we, input logic [3:0] be,
                      input logic [31:0] wd);
    chk({tag, " we"}, {31'b0, mem_we}, {31'b0, we});
    chk({tag, " be"}, {28'b0, mem_be}, {28'b0, be});
    if (we) chk({tag, " wdata"}, mem_wdata, wd);
  endtask

  localparam logic [31:0] OUT = 32'h0800_0000;

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_bad++;
        $display("FAIL R13 watchdog actual=%0d expected<50000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R13 reset sel", {25'b0, mem_sel}, 32'h0);
    chk("R13 reset rd", rd_data, 32'h0);
    chk("R13 reset we", {31'b0, mem_we}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6 stored word is 0 after reset
    drv(1, 0, 2'd2, 32'h0000_0010, 0, OUT, 0);
    chk("R6 reset protected word", rd_data, 32'h0);

    for (int i = 0; i < 18; i++) begin
      logic [97:0] e;
      e = RD_TAB[i];
      drv(1, 0, e[65:64], e[97:66], 0, OUT, 0);
      chk($sformatf("R3/R4/R7/R8 rd #%0d", i), rd_data, e[63:32]);
      chk($sformatf("R1 sel #%0d", i), {25'b0, mem_sel}, {25'b0, e[31:25]});
      chk($sformatf("R2 addr #%0d", i), {7'b0, mem_addr}, {7'b0, e[24:0]});
    end

    // R13 idle
    drv(0, 0, 2'd2, 32'h0200_0000, 0, OUT, 0);
    chk("R13 idle rd", rd_data, 32'h0);
    chk("R13 idle sel", {25'b0, mem_sel}, 32'h0);

    // R5 / R6 boot ROM
    drv(0, 0, 2'd2, 0, 0, 32'h0000_0100, 0);
    chk("R6 look-ahead addr", {18'b0, boot_addr}, 32'h108);
    drv(1, 0, 2'd2, 32'h0000_0010, 0, 32'h0000_0100, 0);
    chk("R5 boot addr", {18'b0, boot_addr}, 32'h10);
    chk("R5 in-boot read", rd_data, 32'hA5A5_0010);
    drv(1, 0, 2'd2, 32'h0000_4000, 0, 32'h0000_0100, 0);
    chk("R5 beyond boot size", rd_data, 32'h0);
    drv(1, 0, 2'd2, 32'h0000_0010, 0, OUT, 0);
    chk("R6 protected word", rd_data, 32'hA5A5_0108);
    drv(1, 0, 2'd2, 32'h0000_0001, 0, OUT, 0);
    chk("R6 protected rotated", rd_data, 32'h08A5_A501);
    drv(1, 0, 2'd0, 32'h0000_0002, 0, OUT, 0);
    chk("R6 protected byte", rd_data, 32'h0000_00A5);
    drv(0, 0, 2'd2, 0, 0, 32'h0000_0200, 1);
    drv(1, 0, 2'd2, 32'h0000_0000, 0, OUT, 0);
    chk("R6 thumb look-ahead", rd_data, 32'hA5A5_0204);
    drv(1, 0, 2'd1, 32'h0000_0002, 0, OUT, 0);
    chk("R6 protected half", rd_data, 32'h0000_A5A5);

    // R9 write lanes
    drv(1, 1, 2'd2, 32'h0200_0003, 32'h1234_5678, OUT, 0);
    wchk("R9 word", 1, 4'hF, 32'h1234_5678);
    chk("R2 write addr", {7'b0, mem_addr}, 32'h3);
    drv(1, 1, 2'd1, 32'h0300_0002, 32'h0000_BEEF, OUT, 0);
    wchk("R9 half", 1, 4'hC, 32'hBEEF_BEEF);
    drv(1, 1, 2'd0, 32'h0400_0001, 32'h0000_005A, OUT, 0);
    wchk("R9 byte", 1, 4'h2, 32'h5A5A_5A5A);
    drv(1, 1, 2'd0, 32'h02FC_0001, 32'h0000_0011, OUT, 0);
    chk("R2 mirror write addr", {7'b0, mem_addr}, 32'h1);

    // R10 video byte stores
    drv(1, 1, 2'd0, 32'h0600_0003, 32'h0000_007C, OUT, 0);
    wchk("R10 video byte dup", 1, 4'hC, 32'h7C7C_7C7C);
    drv(1, 1, 2'd0, 32'h0601_7FFF, 32'h0000_0001, OUT, 0);
    wchk("R10 last duplicated byte", 1, 4'hC, 32'h0101_0101);
    drv(1, 1, 2'd0, 32'h0601_8000, 32'h0000_0001, OUT, 0);
    wchk("R10 object area byte drop", 0, 4'h0, 0);

    // R11 palette / object bytes
    drv(1, 1, 2'd0, 32'h0700_0000, 32'h0000_0001, OUT, 0);
    wchk("R11 object byte drop", 0, 4'h0, 0);
    drv(1, 1, 2'd0, 32'h0500_0001, 32'h0000_0001, OUT, 0);
    wchk("R11 palette byte drop", 0, 4'h0, 0);
    drv(1, 1, 2'd1, 32'h0500_0002, 32'h0000_1234, OUT, 0);
    wchk("R11 palette half kept", 1, 4'hC, 32'h1234_1234);

    // R12 video word near end
    drv(1, 1, 2'd2, 32'h0601_7FFC, 32'hCAFE_F00D, OUT, 0);
    wchk("R12 word below limit", 1, 4'hF, 32'hCAFE_F00D);
    drv(1, 1, 2'd2, 32'h0601_7FFD, 32'hCAFE_F00D, OUT, 0);
    wchk("R12 word just below limit", 1, 4'hF, 32'hCAFE_F00D);
    drv(1, 1, 2'd2, 32'h0601_7FFE, 32'hCAFE_F00D, OUT, 0);
    wchk("R12 word at limit", 0, 4'h0, 0);

    // R8 writes ignored
    drv(1, 1, 2'd2, 32'h0F00_0000, 32'h1, OUT, 0);
    wchk("R8 unmapped write", 0, 4'h0, 0);
    drv(1, 1, 2'd1, 32'h0800_0000, 32'h1, OUT, 0);
    wchk("R8 cartridge write", 0, 4'h0, 0);
    drv(1, 1, 2'd2, 32'h0000_0000, 32'h1, 32'h0000_0100, 0);
    wchk("R8 boot write", 0, 4'h0, 0);

    drv(0, 0, 2'd0, 0, 0, OUT, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule